// File: doc/BRIEF.md
# Latch-addressed register front end

This block is the byte-wide, memory-mapped front end of a legacy floppy controller mode. The register that an access targets is not selected directly by the address. Instead, every bus access, read or write alike, sets or clears one bit of an internal 8-bit latch. The address bits choose which latch bit changes and what value it takes. Three of the latch bits, taken after that update, form a 3-bit register index, and the data part of the same access goes to the register with that index.

Reads return only constant values: register index 0 reads as all ones and every other index reads as zero. Each written byte is kept in an 8-entry shadow register file. Writes to the mode register (index 6) feed a small sequence detector. When bit 6 of those writes follows the pattern 1, 0, 1, 1, the block raises a one-cycle request to switch to the enhanced register mode. The enhanced-mode block answers with a clear pulse, which zeroes the latches.

Top module: `latchreg_front`

## Requirements
- R1: After reset, `latch_state` is 0x00, all shadow entries are 0x00, the detector is at its first stage, `bus_rdata` is 0x00 and `mode_switch_req` is low.
- R2: On a clock edge where `bus_rd` or `bus_wr` is high, the block takes the select nibble `s` from `bus_addr[REG_SHIFT+3:REG_SHIFT]`. Latch bit `s[3:1]` takes the value `s[0]`, the other latch bits keep their values, and `latch_state` shows the result from the next cycle on.
- R3: Address bits below `REG_SHIFT` have no effect on the latch or on the read value.
- R4: The register index of an access is {latch bit 7, latch bit 6, latch bit 4}, with bit 7 as the MSB. It is formed from the latch value already updated by that same access.
- R5: In the cycle after a read, `bus_rdata` is 0xFF if the index is 0 and 0x00 for any other index. `bus_rdata` holds that value until the next read.
- R6: A write stores `bus_wdata` in the shadow entry selected by the index. Entry i appears on `shadow_regs[8*i+7:8*i]` in the cycle after the write.
- R7: Only writes to index 6 advance the detector. Bit 6 of those writes is compared against the expected pattern 1, 0, 1, 1. A write that does not carry the expected bit leaves the detector at its current stage. Writes to any other index leave the detector unchanged.
- R8: A write that completes the pattern raises `mode_switch_req` for exactly one cycle, in the cycle after that write. The detector then returns to its first stage, so the next request needs all four steps again.
- R9: A high `latch_clr` makes `latch_state` 0x00 in the next cycle. This takes priority over the latch update of an access made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid from the cycle after the read |
| latch_clr | input | 1 | Clear pulse from the enhanced-mode block |
| latch_state | output | 8 | Current latch bits |
| shadow_regs | output | 64 | Shadow register file, entry i in bits 8i+7..8i |
| mode_switch_req | output | 1 | One-cycle request to enter the enhanced mode |

## Verification
The checker enforces several rules on every cycle:
- the latch stays still when there is neither an access nor a clear;
- an access flips at most one latch bit;
- a clear always leaves the latch at zero;
- every read answers with the constant that matches the index formed from the updated latch;
- the switch request appears only in the cycle after a write and never lasts two cycles.

Other behaviour depends on the order of accesses, so only the bench scenarios show it. This covers the 1,0,1,1 pattern with stalled steps, writes to other indices left in the middle of a pattern, address bits below the shift having no effect, and the shadow contents after a run of writes.

// File: rtl/latchreg_front.sv
module latchreg_front #(
  parameter int ADDR_W    = 13,
  parameter int REG_SHIFT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              latch_clr,
  output logic [7:0]        latch_state,
  output logic [63:0]       shadow_regs,
  output logic              mode_switch_req
);
  localparam int NREG     = 8;
  localparam int MODE_IDX = 6;
  localparam int TRIG_BIT = 6;

  logic [7:0] latch_q, latch_nxt;
  logic [3:0] sel;
  logic [2:0] idx;
  logic [1:0] stage_q;
  logic       hit, req_q;
  logic [7:0] rdata_q;
  logic [7:0] shadow_q [NREG];

  assign sel = bus_addr[REG_SHIFT +: 4];

  always_comb begin
    latch_nxt = latch_q;
    if (bus_rd || bus_wr) latch_nxt[sel[3:1]] = sel[0];
  end

  assign idx = {latch_nxt[7], latch_nxt[6], latch_nxt[4]};
  assign hit = bus_wr && (idx == 3'(MODE_IDX)) &&
               (bus_wdata[TRIG_BIT] == (stage_q != 2'd1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      rdata_q <= '0;
      stage_q <= '0;
      req_q   <= 1'b0;
    end else begin
      latch_q <= latch_clr ? '0 : latch_nxt;
      if (bus_rd) rdata_q <= (idx == 3'd0) ? 8'hFF : 8'h00;
      req_q   <= hit && (stage_q == 2'd3);
      if (hit) stage_q <= stage_q + 2'd1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_shadow
      always_ff @(posedge clk) begin
        if (!rst_n) shadow_q[g] <= '0;
        else if (bus_wr && idx == 3'(g)) shadow_q[g] <= bus_wdata;
      end
      assign shadow_regs[8*g +: 8] = shadow_q[g];
    end
  endgenerate

  assign bus_rdata       = rdata_q;
  assign latch_state     = latch_q;
  assign mode_switch_req = req_q;
endmodule

// File: rtl/latchreg_front_chk.sv
module latchreg_front_chk #(
  parameter int ADDR_W    = 13,
  parameter int REG_SHIFT = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        bus_rdata,
  input logic              latch_clr,
  input logic [7:0]        latch_state,
  input logic              mode_switch_req
);
  logic [2:0] cur_idx;
  assign cur_idx = {latch_state[7], latch_state[6], latch_state[4]};

  // R2: no access and no clear leaves the latch as it was
  a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && !bus_wr && !latch_clr) |=> $stable(latch_state));

  // R2: an access changes at most one latch bit
  a_r2_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && !latch_clr) |=>
      ($countones(latch_state ^ $past(latch_state)) <= 1));

  // R5: the read answer matches the index formed by the updated latch
  a_r5_read_const: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !latch_clr) |=>
      (bus_rdata == ((cur_idx == 3'd0) ? 8'hFF : 8'h00)));

  // R8: the request never lasts two cycles
  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mode_switch_req |=> !mode_switch_req);

  // R7: the request only follows a write
  a_r7_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_switch_req) |-> $past(bus_wr));

  // R9: a clear always empties the latch
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    latch_clr |=> (latch_state == 8'h00));
endmodule

bind latchreg_front latchreg_front_chk #(.ADDR_W(ADDR_W), .REG_SHIFT(REG_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_rdata(bus_rdata), .latch_clr(latch_clr),
  .latch_state(latch_state), .mode_switch_req(mode_switch_req)
);

// File: tb/latchreg_front_bench.sv
module latchreg_front_bench;
  localparam int ADDR_W = 13;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_rd = 1'b0, bus_wr = 1'b0, latch_clr = 1'b0;
  logic [7:0]        bus_wdata = '0;
  logic [7:0]        bus_rdata, latch_state;
  logic [63:0]       shadow_regs;
  logic              mode_switch_req;

  latchreg_front #(.ADDR_W(ADDR_W), .REG_SHIFT(9)) u_latchreg_front (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .latch_clr(latch_clr), .latch_state(latch_state),
    .shadow_regs(shadow_regs), .mode_switch_req(mode_switch_req)
  );

  always #4 clk = ~clk;

  typedef struct {
    int          due;
    int          what;
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t       q[$];
  int          cyc = 0, checks = 0, failures = 0;
  bit          done = 0;
  logic [7:0]  m_latch = '0, m_rd = '0;
  logic [63:0] m_sh = '0;
  int          m_stage = 0;
  bit          m_req = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int due, int what, logic [63:0] exp, string tag);
    item_t it;
    it.due = due; it.what = what; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic push_all(string tag);
    push(cyc + 1, 0, {56'd0, m_latch}, tag);
    push(cyc + 1, 1, {56'd0, m_rd}, tag);
    push(cyc + 1, 2, {63'd0, m_req}, tag);
    push(cyc + 1, 3, m_sh, tag);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [63:0] act;
      it = q.pop_front();
      case (it.what)
        0: act = {56'd0, latch_state};
        1: act = {56'd0, bus_rdata};
        2: act = {63'd0, mode_switch_req};
        default: act = shadow_regs;
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s item%0d actual=%h expected=%h", it.tag, it.what, act, it.exp);
      end
    end
  end

  // one access; called right after a falling edge
  task automatic acc(bit rd, bit wr, bit clr, logic [3:0] sel, logic [8:0] low,
                     logic [7:0] wd, string tag);
    logic [7:0] nl;
    logic [2:0] ix;
    bit         expb;
    nl = m_latch;
    if (rd || wr) nl[sel[3:1]] = sel[0];
    ix = {nl[7], nl[6], nl[4]};
    if (rd) m_rd = (ix == 3'd0) ? 8'hFF : 8'h00;
    if (wr) m_sh[8*ix +: 8] = wd;
    m_req = 0;
    if (wr && ix == 3'd6) begin
      expb = (m_stage != 1);
      if (wd[6] == expb) begin
        if (m_stage == 3) begin m_req = 1; m_stage = 0; end
        else m_stage++;
      end
    end
    m_latch = clr ? 8'h00 : nl;
    bus_addr = {sel, low}; bus_rd = rd; bus_wr = wr; bus_wdata = wd; latch_clr = clr;
    push_all(tag);
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; latch_clr = 0;
  endtask

  task automatic idle(string tag);
    m_req = 0;
    push_all(tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset state");
    acc(1, 0, 0, 4'h0, 9'h000, 8'h00, "R5 read index 0 gives FF");
    acc(1, 0, 0, 4'h9, 9'h000, 8'h00, "R2 R4 R5 latch4 set, index 1 reads 00");
    acc(0, 1, 0, 4'h8, 9'h000, 8'hAA, "R6 write shadow 0");
    acc(1, 0, 0, 4'h0, 9'h1FF, 8'h00, "R3 low address bits ignored");
    acc(1, 0, 0, 4'hF, 9'h0A5, 8'h00, "R2 latch7 set");
    acc(1, 0, 0, 4'hD, 9'h000, 8'h00, "R4 latch6 set, index 6 reads 00");
    acc(0, 1, 0, 4'h8, 9'h000, 8'h40, "R7 step 1");
    acc(0, 1, 0, 4'h8, 9'h000, 8'h00, "R7 step 0");
    acc(0, 1, 0, 4'h8, 9'h000, 8'h40, "R7 step 1b");
    acc(0, 1, 0, 4'h8, 9'h000, 8'h40, "R8 step final raises request");
    idle("R8 request lasts one cycle");
    acc(0, 1, 0, 4'h8, 9'h000, 8'h40, "R7 stall seq a");
    acc(0, 1, 0, 4'h8, 9'h000, 8'hFF, "R7 mismatch stays");
    acc(0, 1, 0, 4'h8, 9'h000, 8'h00, "R7 stall seq c");
    acc(0, 1, 0, 4'h8, 9'h000, 8'h40, "R7 stall seq d");
    acc(0, 1, 0, 4'h8, 9'h000, 8'h40, "R8 stalled sequence completes");
    acc(0, 1, 0, 4'h8, 9'h000, 8'h40, "R7 other index seq a");
    acc(0, 1, 0, 4'h9, 9'h000, 8'h00, "R7 index 7 write ignored");
    acc(0, 1, 0, 4'h8, 9'h000, 8'h40, "R7 mismatch after ignored write");
    acc(0, 1, 0, 4'h8, 9'h000, 8'h00, "R7 other index seq c");
    acc(0, 1, 0, 4'h8, 9'h000, 8'h40, "R7 other index seq d");
    acc(0, 1, 0, 4'h8, 9'h000, 8'h40, "R8 completes after index 7 write");
    acc(0, 1, 0, 4'h3, 9'h000, 8'h5C, "R6 write index 6 with latch1 set");
    acc(0, 0, 1, 4'h0, 9'h000, 8'h00, "R9 clear pulse");
    acc(1, 0, 0, 4'h0, 9'h000, 8'h00, "R9 read after clear gives FF");
    acc(1, 0, 0, 4'hF, 9'h000, 8'h00, "R2 latch7 set again");
    acc(1, 0, 1, 4'hB, 9'h000, 8'h00, "R9 clear beats access");
    idle("R5 read value holds");
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule